// File: doc/BRIEF.md
# Lockable Flash Control Register

This block is the 32-bit control word of an embedded flash controller, reached through a small register port. Software uses it to select a flash operation: program, fast program, page erase or mass erase of either bank. It also sets the page number and the erase bank, and fires the start strobes that the erase and program engine sees. It holds three interrupt enables as well. These are ANDed with the controller's status flags and ORed into a single interrupt request.

Writes pass through two locks, and both come out of reset closed. The main lock freezes the whole word. It opens only when the correct pair of 32-bit keys is written, back to back, to a key offset. The option lock freezes the option-reload request and the option start strobe. It has its own key pair at a second key offset, and it can be opened only once the main lock is open. A wrong key, a wrong order or a partial key write spoils the attempt for good: that lock then stays closed until the next reset. Software can close either lock again by writing 1 to its bit.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (bit 31 main lock and bit 30 option lock set). Every strobe output is 0 and irq_o is 0.
- R2: Bit 31 can only be set by software. While it is 1, writes to the control word change nothing. It clears only after two consecutive full-word writes to the key offset 0x4, first 0x4567_0123 and then 0xCDEF_89AB. Once clear, writing 1 to it closes the lock again, and a fresh key pair reopens it.
- R3: A key write that is wrong for its step fails the attempt. This covers a wrong value, a wrong order, or byte strobes other than all four. After a failure the lock stays set, even when correct keys follow, until reset.
- R4: Bit 30 can only be set by software. Its keys are 0x0819_2A3B and then 0x4C5D_6E7F, written to offset 0x8. While the main lock is set, writes to offset 0x8 are ignored: they neither open the lock nor count as a failure.
- R5: Writing 1 to bit 27 requests an option reload, but only while the option lock is clear. The bit stays 1, and writing 0 does not clear it, until opt_load_done_i clears it.
- R6: irq_o is (rderr_flag_i AND bit 26) OR (operr_flag_i AND bit 25) OR (eop_flag_i AND bit 24). It follows the inputs in the same cycle.
- R7: The field positions are: bit 18 fast program, bit 15 mass erase of bank 2, bit 11 erase bank, bits 10:3 page number, bit 2 mass erase of bank 1, bit 1 page erase, bit 0 program. Each field drives its output pin.
- R8: Bits 29:28, 23:19 and 14:12 always read 0 and ignore writes.
- R9: A write changes only the byte lanes whose strobe is 1 (strobe bit n covers data bits 8n+7:8n).
- R10: Bit 16 (operation start) and bit 17 (option start) can only be set by software, and op_done_i clears both. Bit 17 can be set only while the option lock is clear.
- R11: While busy_i is 1, writes leave bits 18:15 and 11:0 unchanged. The interrupt enables can still be written.
- R12: A read returns rsp_valid=1 and the data one cycle after the request. Offsets other than 0x0, including both key offsets, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset (0x0 control, 0x4 main key, 0x8 option key) |
| req_be | input | 4 | Byte strobes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| busy_i | input | 1 | Flash operation in progress |
| op_done_i | input | 1 | Operation finished pulse |
| opt_load_done_i | input | 1 | Option reload finished pulse |
| rderr_flag_i | input | 1 | Read-protection error flag |
| operr_flag_i | input | 1 | Operation error flag |
| eop_flag_i | input | 1 | End-of-operation flag |
| prog_o | output | 1 | Program select |
| page_erase_o | output | 1 | Page erase select |
| mass_erase1_o | output | 1 | Mass erase bank 1 |
| mass_erase2_o | output | 1 | Mass erase bank 2 |
| page_o | output | 8 | Page number |
| bank_o | output | 1 | Erase bank select |
| fast_prog_o | output | 1 | Fast program select |
| op_start_o | output | 1 | Operation start strobe |
| opt_start_o | output | 1 | Option start strobe |
| opt_reload_o | output | 1 | Option reload request |
| rderr_ie_o | output | 1 | Read-protection error interrupt enable |
| operr_ie_o | output | 1 | Operation error interrupt enable |
| eop_ie_o | output | 1 | End-of-operation interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the clock edge that samples it. The field outputs and the lock state therefore change one cycle after the request, and a read issued in the next cycle returns the new word one further edge later. irq_o has no register on its path: it is checked a moment after the flags change, within the same cycle. The bench drives every request on a falling edge and holds it for one cycle, and it samples the outputs on the following falling edge, halfway between the edge that acts and the next one. It sweeps all sixteen strobe patterns and all 64 enable and flag combinations, and it computes the expected values arithmetically.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    localparam int WORD_W = 32;
    localparam int PAGE_W = 8;

    // bit positions of the control word
    localparam int B_LOCK     = 31;
    localparam int B_OPTLOCK  = 30;
    localparam int B_RELOAD   = 27;
    localparam int B_IE_LO    = 24;
    localparam int B_FAST     = 18;
    localparam int B_OSTART   = 17;
    localparam int B_START    = 16;
    localparam int B_MER2     = 15;
    localparam int B_BANK     = 11;
    localparam int B_PAGE_LO  = 3;
    localparam int B_MER1     = 2;
    localparam int B_PER      = 1;
    localparam int B_PG       = 0;
    localparam int IE_N       = 3;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_ARMED  = 2'd1,
        KS_FAILED = 2'd2
    } key_state_e;

    typedef struct packed {
        logic              lock;
        logic              opt_lock;
        logic              reload;
        logic [IE_N-1:0]   ien;      // [2]=rderr [1]=operr [0]=eop
        logic              fast;
        logic              opt_start;
        logic              start;
        logic              mer2;
        logic              bank;
        logic [PAGE_W-1:0] page;
        logic              mer1;
        logic              per;
        logic              pg;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{lock: 1'b1, opt_lock: 1'b1, default: '0};

    function automatic logic [WORD_W-1:0] pack_word(input ctl_fields_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_LOCK]                       = f.lock;
        w[B_OPTLOCK]                    = f.opt_lock;
        w[B_RELOAD]                     = f.reload;
        w[B_IE_LO +: IE_N]              = f.ien;
        w[B_FAST]                       = f.fast;
        w[B_OSTART]                     = f.opt_start;
        w[B_START]                      = f.start;
        w[B_MER2]                       = f.mer2;
        w[B_BANK]                       = f.bank;
        w[B_PAGE_LO +: PAGE_W]          = f.page;
        w[B_MER1]                       = f.mer1;
        w[B_PER]                        = f.per;
        w[B_PG]                         = f.pg;
        return w;
    endfunction

endpackage

// File: rtl/fcr_lane_mask.sv
module fcr_lane_mask #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int MASK_W = LANES * LANE_W
) (
    input  logic [LANES-1:0]  be_i,
    output logic [MASK_W-1:0] mask_o
);
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign mask_o[ln*LANE_W +: LANE_W] = {LANE_W{be_i[ln]}};
    end
endmodule

// File: rtl/fcr_key_seq.sv
module fcr_key_seq #(
    parameter int               KEY_W      = 32,
    parameter logic [KEY_W-1:0] KEY_FIRST  = '0,
    parameter logic [KEY_W-1:0] KEY_SECOND = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,   // lock closed and eligible for opening
    input  logic             key_wr_i,
    input  logic             key_full_i,
    input  logic [KEY_W-1:0] key_data_i,
    output logic             unlock_o,
    output logic             failed_o
);
    import fcr_pkg::*;

    typedef struct packed {
        key_state_e st;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        unlock_o = 1'b0;
        if (armed_i && key_wr_i) begin
            unique case (s_q.st)
                KS_IDLE: begin
                    if (key_full_i && key_data_i == KEY_FIRST) s_d.st = KS_ARMED;
                    else                                       s_d.st = KS_FAILED;
                end
                KS_ARMED: begin
                    if (key_full_i && key_data_i == KEY_SECOND) begin
                        s_d.st   = KS_IDLE;
                        unlock_o = 1'b1;
                    end else begin
                        s_d.st = KS_FAILED;
                    end
                end
                default: s_d.st = KS_FAILED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: KS_IDLE};
        else        s_q <= s_d;
    end

    assign failed_o = (s_q.st == KS_FAILED);
endmodule

// File: rtl/fcr_irq.sv
module fcr_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_src
        assign hit[i] = flag_i[i] & en_i[i];
    end
    assign irq_o = |hit;
endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg #(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter logic [3:0]  CTRL_ADDR   = 4'h0,
    parameter logic [3:0]  KEY_ADDR    = 4'h4,
    parameter logic [3:0]  OPTKEY_ADDR = 4'h8,
    parameter logic [31:0] MKEY_A      = 32'h4567_0123,
    parameter logic [31:0] MKEY_B      = 32'hCDEF_89AB,
    parameter logic [31:0] OKEY_A      = 32'h0819_2A3B,
    parameter logic [31:0] OKEY_B      = 32'h4C5D_6E7F,
    localparam int         STRB_W      = DATA_W / 8,
    localparam int         PG_W        = fcr_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [STRB_W-1:0] req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              busy_i,
    input  logic              op_done_i,
    input  logic              opt_load_done_i,
    input  logic              rderr_flag_i,
    input  logic              operr_flag_i,
    input  logic              eop_flag_i,
    output logic              prog_o,
    output logic              page_erase_o,
    output logic              mass_erase1_o,
    output logic              mass_erase2_o,
    output logic [PG_W-1:0]   page_o,
    output logic              bank_o,
    output logic              fast_prog_o,
    output logic              op_start_o,
    output logic              opt_start_o,
    output logic              opt_reload_o,
    output logic              rderr_ie_o,
    output logic              operr_ie_o,
    output logic              eop_ie_o,
    output logic              irq_o
);
    import fcr_pkg::*;

    typedef struct packed {
        ctl_fields_t       f;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t r_d, r_q;

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] wset;
    logic [DATA_W-1:0] merged;
    logic              main_lock, opt_lock;
    logic              main_unlock, opt_unlock;
    logic              main_failed, opt_failed;
    logic              wr_ctrl, wr_key, wr_optkey, full_word;

    assign main_lock = r_q.f.lock;
    assign opt_lock  = r_q.f.opt_lock;

    fcr_lane_mask #(.LANES(STRB_W), .LANE_W(8)) u_mask (
        .be_i   (req_be),
        .mask_o (wmask)
    );

    assign full_word = &req_be;
    assign wr_ctrl   = req_valid && req_write && (req_addr == CTRL_ADDR);
    assign wr_key    = req_valid && req_write && (req_addr == KEY_ADDR);
    assign wr_optkey = req_valid && req_write && (req_addr == OPTKEY_ADDR);

    fcr_key_seq #(.KEY_W(DATA_W), .KEY_FIRST(MKEY_A), .KEY_SECOND(MKEY_B)) u_main_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (main_lock),
        .key_wr_i   (wr_key),
        .key_full_i (full_word),
        .key_data_i (req_wdata),
        .unlock_o   (main_unlock),
        .failed_o   (main_failed)
    );

    fcr_key_seq #(.KEY_W(DATA_W), .KEY_FIRST(OKEY_A), .KEY_SECOND(OKEY_B)) u_opt_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed_i    (opt_lock && !main_lock),
        .key_wr_i   (wr_optkey),
        .key_full_i (full_word),
        .key_data_i (req_wdata),
        .unlock_o   (opt_unlock),
        .failed_o   (opt_failed)
    );

    // lane-merged image for read/write fields, raw set image for set-only bits
    assign merged = (pack_word(r_q.f) & ~wmask) | (req_wdata & wmask);
    assign wset   = req_wdata & wmask;

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = req_valid && !req_write;
        r_d.rdata  = (req_valid && !req_write && req_addr == CTRL_ADDR)
                     ? pack_word(r_q.f) : '0;

        if (wr_ctrl && !main_lock) begin
            if (wset[B_LOCK])    r_d.f.lock     = 1'b1;
            if (wset[B_OPTLOCK]) r_d.f.opt_lock = 1'b1;
            if (wset[B_RELOAD] && !opt_lock) r_d.f.reload = 1'b1;
            r_d.f.ien = merged[B_IE_LO +: IE_N];
            if (!busy_i) begin
                r_d.f.fast = merged[B_FAST];
                r_d.f.mer2 = merged[B_MER2];
                r_d.f.bank = merged[B_BANK];
                r_d.f.page = merged[B_PAGE_LO +: PAGE_W];
                r_d.f.mer1 = merged[B_MER1];
                r_d.f.per  = merged[B_PER];
                r_d.f.pg   = merged[B_PG];
                if (wset[B_START])                r_d.f.start     = 1'b1;
                if (wset[B_OSTART] && !opt_lock)  r_d.f.opt_start = 1'b1;
            end
        end

        if (main_unlock) r_d.f.lock     = 1'b0;
        if (opt_unlock)  r_d.f.opt_lock = 1'b0;

        if (op_done_i) begin
            r_d.f.start     = 1'b0;
            r_d.f.opt_start = 1'b0;
        end
        if (opt_load_done_i) r_d.f.reload = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{f: CTL_RESET, rvalid: 1'b0, rdata: '0};
        else        r_q <= r_d;
    end

    fcr_irq #(.N(IE_N)) u_irq (
        .flag_i ({rderr_flag_i, operr_flag_i, eop_flag_i}),
        .en_i   (r_q.f.ien),
        .irq_o  (irq_o)
    );

    assign rsp_valid     = r_q.rvalid;
    assign rsp_rdata     = r_q.rdata;
    assign prog_o        = r_q.f.pg;
    assign page_erase_o  = r_q.f.per;
    assign mass_erase1_o = r_q.f.mer1;
    assign mass_erase2_o = r_q.f.mer2;
    assign page_o        = r_q.f.page;
    assign bank_o        = r_q.f.bank;
    assign fast_prog_o   = r_q.f.fast;
    assign op_start_o    = r_q.f.start;
    assign opt_start_o   = r_q.f.opt_start;
    assign opt_reload_o  = r_q.f.reload;
    assign rderr_ie_o    = r_q.f.ien[2];
    assign operr_ie_o    = r_q.f.ien[1];
    assign eop_ie_o      = r_q.f.ien[0];

    logic unused_ok;
    assign unused_ok = ^{opt_failed, merged[31:27], merged[23:19], merged[17:16],
                         merged[14:12], wset[29:28], wset[26:19], wset[15:0]};
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
    parameter int         ADDR_W   = 4,
    parameter logic [3:0] KEY_ADDR = 4'h4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              main_lock,
    input logic              opt_lock,
    input logic              main_failed,
    input logic [2:0]        ien,
    input logic [13:0]       op_sel,
    input logic              reload,
    input logic              opt_load_done,
    input logic              busy,
    input logic [2:0]        flags,
    input logic              irq,
    input logic [31:0]       rdata
);
    localparam logic [31:0] RSVD = 32'h30F8_7000;

    assert_main_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_lock) |-> $past(req_valid && req_write && req_addr == KEY_ADDR));

    assert_locked_word_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        main_lock |=> $stable(ien));

    assert_failed_stays_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        main_failed |-> main_lock);

    assert_opt_after_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(opt_lock) |-> $past(!main_lock));

    assert_reload_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !opt_load_done) |=> reload);

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 3'b000 || flags == 3'b000) |-> !irq);

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & RSVD) == 32'h0);

    assert_busy_blocks_ops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_sel));
endmodule

bind flash_ctl_reg fcr_checker #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .main_lock     (main_lock),
    .opt_lock      (opt_lock),
    .main_failed   (main_failed),
    .ien           ({rderr_ie_o, operr_ie_o, eop_ie_o}),
    .op_sel        ({fast_prog_o, mass_erase2_o, bank_o, page_o, mass_erase1_o, page_erase_o, prog_o}),
    .reload        (opt_reload_o),
    .opt_load_done (opt_load_done_i),
    .busy          (busy_i),
    .flags         ({rderr_flag_i, operr_flag_i, eop_flag_i}),
    .irq           (irq_o),
    .rdata         (rsp_rdata)
);

// File: tb/flash_ctl_reg_bench.sv
module flash_ctl_reg_bench;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_KEY  = 4'h4;
    localparam logic [3:0] A_OKEY = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        busy_i = 1'b0, op_done_i = 1'b0, opt_load_done_i = 1'b0;
    logic        rderr_flag_i = 1'b0, operr_flag_i = 1'b0, eop_flag_i = 1'b0;
    logic        prog_o, page_erase_o, mass_erase1_o, mass_erase2_o;
    logic [7:0]  page_o;
    logic        bank_o, fast_prog_o, op_start_o, opt_start_o, opt_reload_o;
    logic        rderr_ie_o, operr_ie_o, eop_ie_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    flash_ctl_reg u_flash_ctl_reg (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy_i(busy_i),
        .op_done_i(op_done_i), .opt_load_done_i(opt_load_done_i),
        .rderr_flag_i(rderr_flag_i), .operr_flag_i(operr_flag_i), .eop_flag_i(eop_flag_i),
        .prog_o(prog_o), .page_erase_o(page_erase_o), .mass_erase1_o(mass_erase1_o),
        .mass_erase2_o(mass_erase2_o), .page_o(page_o), .bank_o(bank_o),
        .fast_prog_o(fast_prog_o), .op_start_o(op_start_o), .opt_start_o(opt_start_o),
        .opt_reload_o(opt_reload_o), .rderr_ie_o(rderr_ie_o), .operr_ie_o(operr_ie_o),
        .eop_ie_o(eop_ie_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    task automatic expect_word(input string req, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        rd(A_CTRL, d, v);
        check(req, {31'd0, v}, 32'd1);
        check(req, d, exp);
    endtask

    task automatic main_unlock();
        wr(A_KEY, 32'h4567_0123, 4'hF);
        wr(A_KEY, 32'hCDEF_89AB, 4'hF);
    endtask

    task automatic opt_unlock();
        wr(A_OKEY, 32'h0819_2A3B, 4'hF);
        wr(A_OKEY, 32'h4C5D_6E7F, 4'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        logic [31:0] pat;
        logic [31:0] lm;
        logic [31:0] e;
        do_reset();

        // R1 reset state
        expect_word("R1 reset word", 32'hC000_0000);
        check("R1 start strobes", {30'd0, op_start_o, opt_start_o}, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);

        // R12 key offsets read zero, response one cycle later
        rd(A_KEY, d, v);
        check("R12 key offset reads 0", d, 32'h0);
        check("R12 rsp_valid", {31'd0, v}, 32'd1);
        rd(A_OKEY, d, v);
        check("R12 optkey offset reads 0", d, 32'h0);

        // R2 writes ignored while locked
        wr(A_CTRL, 32'h0701_0FFF, 4'hF);
        expect_word("R2 locked write ignored", 32'hC000_0000);

        // R3 wrong first key, then correct keys
        wr(A_KEY, 32'h1234_5678, 4'hF);
        main_unlock();
        expect_word("R3 wrong value stays locked", 32'hC000_0000);
        do_reset();
        wr(A_KEY, 32'hCDEF_89AB, 4'hF);
        wr(A_KEY, 32'h4567_0123, 4'hF);
        main_unlock();
        expect_word("R3 wrong order stays locked", 32'hC000_0000);
        do_reset();
        wr(A_KEY, 32'h4567_0123, 4'hF);
        wr(A_KEY, 32'hCDEF_89AB, 4'h7);
        main_unlock();
        expect_word("R3 partial strobe stays locked", 32'hC000_0000);

        // R4 option keys ignored while main locked, then R2/R4 proper order
        do_reset();
        opt_unlock();
        expect_word("R4 optkeys ignored under main lock", 32'hC000_0000);
        main_unlock();
        expect_word("R2 main unlock", 32'h4000_0000);

        // R5/R10 option bits blocked by option lock
        wr(A_CTRL, 32'h0802_0000, 4'hF);
        expect_word("R5 reload blocked by option lock", 32'h4000_0000);
        check("R10 opt start blocked", {31'd0, opt_start_o}, 32'd0);
        opt_unlock();
        expect_word("R4 option unlock after main", 32'h0000_0000);

        // R5 reload request held until done
        wr(A_CTRL, 32'h0800_0000, 4'hF);
        expect_word("R5 reload set", 32'h0800_0000);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h0000_0000, 4'hF);
        expect_word("R5 reload ignores 0", 32'h0800_0000);
        check("R5 reload pin", {31'd0, opt_reload_o}, 32'd1);
        @(negedge clk); opt_load_done_i = 1'b1;
        @(negedge clk); opt_load_done_i = 1'b0;
        expect_word("R5 reload cleared by done", 32'h0000_0000);

        // R9/R7 byte-lane sweep
        pat = 32'h0704_8FFF;
        for (int be = 0; be < 16; be++) begin
            wr(A_CTRL, 32'h0, 4'hF);
            wr(A_CTRL, pat, be[3:0]);
            lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            e  = pat & lm;
            expect_word("R9 byte lanes", e);
            check("R7 page field", {24'd0, page_o}, {24'd0, e[10:3]});
            check("R7 single-bit fields",
                  {25'd0, fast_prog_o, mass_erase2_o, bank_o, mass_erase1_o, page_erase_o, prog_o, eop_ie_o},
                  {25'd0, e[18], e[15], e[11], e[2], e[1], e[0], e[24]});
        end

        // R8 reserved bits
        wr(A_CTRL, 32'h30F8_7000, 4'hF);
        expect_word("R8 reserved read 0", 32'h0);

        // R10 start strobes
        wr(A_CTRL, 32'h0001_0000, 4'hF);
        expect_word("R10 start set", 32'h0001_0000);
        check("R10 start pin", {31'd0, op_start_o}, 32'd1);
        wr(A_CTRL, 32'h0000_0000, 4'hF);
        expect_word("R10 start set-only", 32'h0001_0000);
        @(negedge clk); op_done_i = 1'b1;
        @(negedge clk); op_done_i = 1'b0;
        expect_word("R10 start cleared by done", 32'h0);
        wr(A_CTRL, 32'h0002_0000, 4'hF);
        check("R10 opt start set", {31'd0, opt_start_o}, 32'd1);
        @(negedge clk); op_done_i = 1'b1;
        @(negedge clk); op_done_i = 1'b0;
        check("R10 opt start cleared", {31'd0, opt_start_o}, 32'd0);

        // R11 busy blocks operation bits
        busy_i = 1'b1;
        wr(A_CTRL, 32'h0705_8FFF, 4'hF);
        expect_word("R11 busy keeps op bits, enables written", 32'h0700_0000);
        busy_i = 1'b0;

        // R6 interrupt gating, all 64 combinations
        for (int en = 0; en < 8; en++) begin
            wr(A_CTRL, {5'd0, en[2:0], 24'd0}, 4'hF);
            for (int fl = 0; fl < 8; fl++) begin
                rderr_flag_i = fl[2]; operr_flag_i = fl[1]; eop_flag_i = fl[0];
                #1;
                check("R6 irq gating", {31'd0, irq_o},
                      {31'd0, (en[2] & fl[2]) | (en[1] & fl[1]) | (en[0] & fl[0])});
            end
        end
        rderr_flag_i = 1'b0; operr_flag_i = 1'b0; eop_flag_i = 1'b0;

        // R2 relock and reopen
        wr(A_CTRL, 32'h0, 4'hF);
        wr(A_CTRL, 32'h8000_0000, 4'hF);
        expect_word("R2 relock", 32'h8000_0000);
        wr(A_CTRL, 32'h0100_0000, 4'hF);
        expect_word("R2 relocked write ignored", 32'h8000_0000);
        main_unlock();
        expect_word("R2 reopen after relock", 32'h0);

        summary();
        $finish;
    end
endmodule